// File: doc/BRIEF.md
# Bus-Mapped Indicator Panel Controller

This block is a slave on a simple 32-bit bus that carries only two kinds of request: fetch and store. It owns a small window of three word registers. One switches a display on or off, one sets a brightness level, and one holds a bank of individual indicator lights. It compares each request's address against its window and takes no action on any address outside it. No other device is expected to answer for those addresses on its behalf.

A requester presents a request for one cycle by raising `req_valid`, together with the address, the operation and the store data. The block looks at the address, the operation and the data value in the same cycle. Stores change the panel state at the accepting clock edge. One clock after an in-range request, the block raises `done` for exactly one cycle. For a fetch, the answer appears on `rd_data` in that same cycle. The display register reacts to the store value rather than to one bit: any nonzero value switches the display on, and zero switches it off.

Top module: `lamp_panel_slave`

## Requirements
- R1: After reset the display is off, `level` is 0, all `lamps` are 0, and `done` is low.
- R2: The window is byte addresses BASE_ADDR to BASE_ADDR+11 (100 to 111 by default). A request at any other address never raises `done` and leaves `disp_on`, `level` and `lamps` unchanged.
- R3: A store to display bytes 100–103 switches `disp_on` to 1 when the 32-bit data has any bit set, including only the top bit, and to 0 when the data is all zeros. All four byte addresses reach the same register.
- R4: A fetch from 100–103 returns exactly 32'h1 while the display is on and 32'h0 while it is off.
- R5: A store to 104–107 loads `level` from data bits [3:0] and ignores bits [31:4]. 0 is the dimmest level and 15 the brightest.
- R6: A store to 108–111 loads the sixteen lights from data bits [15:0], with bit i driving `lamps[i]` (1 = on, 0 = off), and ignores bits [31:16].
- R7: A fetch from 104–107 returns `level` zero-extended to 32 bits, and a fetch from 108–111 returns `lamps` zero-extended. A fetch changes no panel state.
- R8: Every in-range request raises `done` high for exactly the one cycle after the accepting edge. Back-to-back requests give one pulse each. `rd_data` is 0 when a store completes.
- R9: The new state from a store is already on `disp_on`, `level` and `lamps` in the cycle its `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe |
| req_store | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| done | output | 1 | Completion pulse, one cycle after acceptance |
| rd_data | output | 32 | Fetch result, valid while `done` is high |
| disp_on | output | 1 | Display enable |
| level | output | 4 | Brightness, 0 dimmest to 15 brightest |
| lamps | output | 16 | Individual indicator lights |

## Verification
Every panel register drives an output pin directly, so a wrong stored value shows on `disp_on`, `level` or `lamps` in the same cycle that `done` reports the store. The bench compares those pins at every completion. A decode fault that lets a foreign address in shows up one cycle later as a `done` pulse with nothing expected. It also shows as a changed pin at the next idle check. A wrong read mux or extension shows up only when the value is fetched, so every register is read back after it is written.

// File: rtl/lamp_panel_pkg.sv
package lamp_panel_pkg;
   typedef enum logic [1:0] {
      SEL_DISP  = 2'd0,
      SEL_LEVEL = 2'd1,
      SEL_LAMPS = 2'd2,
      SEL_NONE  = 2'd3
   } lp_sel_e;

   localparam int LP_WORDS      = 3;
   localparam int LP_WORD_BYTES = 4;
endpackage

// File: rtl/lamp_addr_decode.sv
module lamp_addr_decode
   import lamp_panel_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 100
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output lp_sel_e           sel
);
   localparam int               SPAN   = LP_WORDS * LP_WORD_BYTES;
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(SPAN);

   initial begin
      assert (BASE_ADDR % LP_WORD_BYTES == 0)
         else $error("window base must be word aligned");
      assert (BASE_ADDR + SPAN <= (1 << ADDR_W))
         else $error("window does not fit in the address space");
   end

   logic [ADDR_W-1:0] offs;

   always_comb begin
      offs = addr - BASE_V;
      hit  = (offs < SPAN_V);
      sel  = SEL_NONE;
      if (hit) begin
         unique case (offs[3:2])
            2'd0:    sel = SEL_DISP;
            2'd1:    sel = SEL_LEVEL;
            2'd2:    sel = SEL_LAMPS;
            default: sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/lamp_ctrl_regs.sv
module lamp_ctrl_regs
   import lamp_panel_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int LEVEL_W  = 4,
   parameter int LAMP_CNT = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  lp_sel_e             sel,
   input  logic [DATA_W-1:0]   wdata,
   output logic                disp_on,
   output logic [LEVEL_W-1:0]  level,
   output logic [LAMP_CNT-1:0] lamps
);
   initial begin
      assert (LAMP_CNT >= 1 && LAMP_CNT <= DATA_W) else $error("bad LAMP_CNT");
      assert (LEVEL_W >= 1 && LEVEL_W <= DATA_W)   else $error("bad LEVEL_W");
   end

   logic wr_disp, wr_level, wr_lamps;
   assign wr_disp  = wr_en && (sel == SEL_DISP);
   assign wr_level = wr_en && (sel == SEL_LEVEL);
   assign wr_lamps = wr_en && (sel == SEL_LAMPS);

   always_ff @(posedge clk) begin
      if (rst)          disp_on <= 1'b0;
      else if (wr_disp) disp_on <= |wdata;
   end

   always_ff @(posedge clk) begin
      if (rst)           level <= '0;
      else if (wr_level) level <= wdata[LEVEL_W-1:0];
   end

   for (genvar gi = 0; gi < LAMP_CNT; gi++) begin : g_lamp
      logic lamp_q;
      always_ff @(posedge clk) begin
         if (rst)           lamp_q <= 1'b0;
         else if (wr_lamps) lamp_q <= wdata[gi];
      end
      assign lamps[gi] = lamp_q;
   end

   a_r3_nonzero_on: assert property (@(posedge clk) disable iff (rst)
      (wr_disp && (wdata != '0)) |=> disp_on);
   a_r3_zero_off: assert property (@(posedge clk) disable iff (rst)
      (wr_disp && (wdata == '0)) |=> !disp_on);
   a_r5_low_nibble: assert property (@(posedge clk) disable iff (rst)
      wr_level |=> (level == $past(wdata[LEVEL_W-1:0])));
   a_r6_lamp_bits: assert property (@(posedge clk) disable iff (rst)
      wr_lamps |=> (lamps == $past(wdata[LAMP_CNT-1:0])));
   a_r2_hold_state: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ($stable(disp_on) && $stable(level) && $stable(lamps)));
endmodule

// File: rtl/lamp_read_mux.sv
module lamp_read_mux
   import lamp_panel_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int LEVEL_W  = 4,
   parameter int LAMP_CNT = 16
) (
   input  lp_sel_e             sel,
   input  logic                disp_on,
   input  logic [LEVEL_W-1:0]  level,
   input  logic [LAMP_CNT-1:0] lamps,
   output logic [DATA_W-1:0]   rdata
);
   always_comb begin
      unique case (sel)
         SEL_DISP:  rdata = DATA_W'(disp_on);
         SEL_LEVEL: rdata = DATA_W'(level);
         SEL_LAMPS: rdata = DATA_W'(lamps);
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/lamp_panel_slave.sv
module lamp_panel_slave
   import lamp_panel_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int BASE_ADDR = 100,
   parameter int LEVEL_W   = 4,
   parameter int LAMP_CNT  = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                done,
   output logic [DATA_W-1:0]   rd_data,
   output logic                disp_on,
   output logic [LEVEL_W-1:0]  level,
   output logic [LAMP_CNT-1:0] lamps
);
   logic              hit;
   lp_sel_e           sel;
   logic              accept;
   logic [DATA_W-1:0] mux_data;

   lamp_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr (req_addr),
      .hit  (hit),
      .sel  (sel)
   );

   assign accept = req_valid && hit;

   lamp_ctrl_regs #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .LAMP_CNT(LAMP_CNT)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (accept && req_store),
      .sel     (sel),
      .wdata   (req_wdata),
      .disp_on (disp_on),
      .level   (level),
      .lamps   (lamps)
   );

   lamp_read_mux #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .LAMP_CNT(LAMP_CNT)) u_mux (
      .sel     (sel),
      .disp_on (disp_on),
      .level   (level),
      .lamps   (lamps),
      .rdata   (mux_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done    <= 1'b0;
         rd_data <= '0;
      end else begin
         done    <= accept;
         rd_data <= (accept && !req_store) ? mux_data : '0;
      end
   end

   a_r8_done_needs_request: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(req_valid));
   a_r2_no_done_outside: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !hit) |=> !done);
   a_r8_done_after_accept: assert property (@(posedge clk) disable iff (rst)
      (req_valid && hit) |=> done);
   a_r4_disp_fetch: assert property (@(posedge clk) disable iff (rst)
      (req_valid && hit && !req_store && sel == SEL_DISP)
         |=> (rd_data == DATA_W'($past(disp_on))));
   a_r8_store_rdata_zero: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_store) |=> (rd_data == '0));
endmodule

// File: tb/lamp_panel_slave_tb_top.sv
module lamp_panel_slave_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_store;
   logic [15:0] req_addr;
   logic [31:0] req_wdata;
   logic        done;
   logic [31:0] rd_data;
   logic        disp_on;
   logic [3:0]  level;
   logic [15:0] lamps;

   always #10 clk = ~clk;

   lamp_panel_slave dut_i (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_store (req_store),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .done      (done),
      .rd_data   (rd_data),
      .disp_on   (disp_on),
      .level     (level),
      .lamps     (lamps)
   );

   typedef struct {
      string       tag;
      logic [31:0] rdata;
      logic        disp;
      logic [3:0]  lvl;
      logic [15:0] lmp;
   } exp_item_t;

   exp_item_t   sb_q[$];
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          running  = 1'b0;
   bit          finished = 1'b0;

   logic        m_disp  = 1'b0;
   logic [3:0]  m_level = 4'd0;
   logic [15:0] m_lamps = 16'd0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: called at a falling edge, returns at the next falling edge
   task automatic bus_op(bit st, logic [15:0] a, logic [31:0] d, string tag);
      exp_item_t it;
      bit        inwin;
      inwin = (a >= 16'd100) && (a <= 16'd111);
      req_valid = 1'b1;
      req_store = st;
      req_addr  = a;
      req_wdata = d;
      if (inwin) begin
         it.tag   = tag;
         it.rdata = 32'h0;
         if (st) begin
            if (a <= 16'd103)      m_disp  = (d != 32'h0);
            else if (a <= 16'd107) m_level = d[3:0];
            else                   m_lamps = d[15:0];
         end else begin
            if (a <= 16'd103)      it.rdata = m_disp ? 32'h1 : 32'h0;
            else if (a <= 16'd107) it.rdata = {28'h0, m_level};
            else                   it.rdata = {16'h0, m_lamps};
         end
         it.disp = m_disp;
         it.lvl  = m_level;
         it.lmp  = m_lamps;
         sb_q.push_back(it);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic idle_check(string tag);
      repeat (2) @(negedge clk);
      check(tag, {31'h0, disp_on}, {31'h0, m_disp},  "disp_on after ignored request");
      check(tag, {28'h0, level},   {28'h0, m_level}, "level after ignored request");
      check(tag, {16'h0, lamps},   {16'h0, m_lamps}, "lamps after ignored request");
   endtask

   // monitor: compares every completion against the scoreboard
   always @(negedge clk) begin
      if (running) begin
         if (done) begin
            if (sb_q.size() == 0) begin
               n_checks++;
               n_fail++;
               $display("FAIL R2 done with no request pending actual=1 expected=0");
            end else begin
               exp_item_t it;
               it = sb_q.pop_front();
               check(it.tag, rd_data, it.rdata, "rd_data");
               check({it.tag, "/R9"}, {11'h0, disp_on, level, lamps},
                     {11'h0, it.disp, it.lvl, it.lmp}, "panel outputs");
            end
         end
      end
   end

   initial begin
      #3_000_000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1", {15'h0, done, disp_on, level, lamps[10:0]}, 32'h0, "reset outputs");
      check("R1", {16'h0, lamps}, 32'h0, "reset lamps");
      running = 1'b1;

      // R3 display switching, every byte lane of the word
      bus_op(1, 16'd100, 32'h0000_0005, "R3");
      bus_op(0, 16'd100, 32'h0, "R4");
      bus_op(0, 16'd103, 32'h0, "R4");
      bus_op(1, 16'd102, 32'h8000_0000, "R3");
      bus_op(0, 16'd101, 32'h0, "R4");
      bus_op(1, 16'd101, 32'h0, "R3");
      bus_op(0, 16'd100, 32'h0, "R4");
      bus_op(1, 16'd103, 32'hFFFF_FFFF, "R3");

      // R5 brightness from the low nibble
      bus_op(1, 16'd104, 32'hFFFF_FFF7, "R5");
      bus_op(0, 16'd105, 32'h0, "R7");
      bus_op(1, 16'd107, 32'h0000_000F, "R5");
      bus_op(1, 16'd106, 32'h0000_0010, "R5");
      bus_op(0, 16'd104, 32'h0, "R7");
      bus_op(1, 16'd104, 32'h1234_567A, "R5");

      // R6 lights from the low sixteen bits
      bus_op(1, 16'd108, 32'hABCD_5A3C, "R6");
      bus_op(0, 16'd111, 32'h0, "R7");
      for (int i = 0; i < 16; i++) begin
         bus_op(1, 16'd109, 32'hFFFF_0000 | (32'h1 << i), "R6");
         bus_op(0, 16'd108, 32'h0, "R7");
      end
      bus_op(1, 16'd110, 32'h0000_FFFF, "R6");

      // R7 fetches leave the state alone
      bus_op(0, 16'd100, 32'h0, "R7");
      bus_op(0, 16'd104, 32'h0, "R7");
      repeat (2) @(negedge clk);

      // R2 addresses outside the window
      bus_op(1, 16'd99,   32'h0, "R2");  idle_check("R2");
      bus_op(1, 16'd112,  32'h0, "R2");  idle_check("R2");
      bus_op(1, 16'd0,    32'h0, "R2");  idle_check("R2");
      bus_op(1, 16'hFFFF, 32'h0, "R2");  idle_check("R2");
      bus_op(0, 16'd96,   32'h0, "R2");  idle_check("R2");
      bus_op(1, 16'd112,  32'hFFFF_FFFF, "R2"); idle_check("R2");

      // R8 back-to-back requests, each one pulse
      bus_op(1, 16'd100, 32'h0, "R8");
      bus_op(1, 16'd104, 32'h3, "R8");
      bus_op(0, 16'd100, 32'h0, "R8");
      bus_op(0, 16'd104, 32'h0, "R8");
      bus_op(1, 16'd108, 32'h0, "R8");
      @(negedge clk);
      @(negedge clk);
      check("R8", {31'h0, done}, 32'h0, "done low after burst");
      check("R8", sb_q.size(), 0, "pending completions");

      running  = 1'b0;
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule